// File: doc/BRIEF.md
# Write Intensity Prediction Queue

This block keeps a small, fully associative history of cache write hits so that blocks written often can be moved into the fast-write, low-retention region of a cache. Each of its entries holds a block address, a saturating write counter and an age rank. A write hit to an address already tracked adds one to that entry's counter. A write hit to an untracked address claims a free entry, or takes over the least recently used entry when none is free. Every entry that is used moves to the most recently used position.

A decay event occurs whenever the low bits of the free-running cycle counter are all zero. At each decay event every tracked counter loses one, so addresses that stop being written leave the table. When a write hit raises an entry's count to the swap level and the block is not already in the low-retention region, the block emits a one-cycle swap request that carries the address. It then releases the entry. The swap itself, the cache arrays and the read path belong to other blocks.

Top module: `wr_intensity_queue`

## Requirements
- R1: After reset every entry is free and `swapReq` is low.
- R2: A write hit to a tracked address adds one to that entry's count. The count saturates at 2^CNT_W-1 (15 by default).
- R3: A write hit to an untracked address takes a free entry, if one exists, with a starting count of 1. By default an address therefore requests a swap on its 11th write after it is inserted.
- R4: A write to an untracked address when no entry is free replaces the least recently used entry. Each hit or insertion makes that entry the most recently used.
- R5: A decay event occurs in a cycle where `cycleCnt` is all zeros. In that cycle every tracked entry loses one from its count, except the entry that the same cycle's write hit touches. An entry that reaches 0 is freed.
- R6: The swap request fires on a write hit that makes a count reach SWAP_LEVEL (default 11) while `wrInLowRet` is 0. `swapReq` is then high in the next cycle, and `swapAddr` equals the written address. The entry is freed.
- R7: A write hit with `wrInLowRet` at 1 never causes a request. Its count still advances and saturates.
- R8: `swapReq` is high only in the cycle that directly follows a qualifying write hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrHit | input | 1 | A write hit occurs this cycle |
| wrAddr | input | ADDR_W | Block address of the write hit |
| wrInLowRet | input | 1 | The block already lies in the low-retention region |
| cycleCnt | input | DECAY_LOG2 | Low bits of the free-running cycle counter; all zeros marks a decay event |
| swapReq | output | 1 | One-cycle request to move a block into the low-retention region |
| swapAddr | output | ADDR_W | Address that goes with `swapReq` |

## Verification
All table state changes at the clock edge that samples a write hit or a decay event. `swapReq` and `swapAddr` are registered, so a request is due in the cycle after the qualifying write. The bench changes inputs on falling edges. It reads the request output on the falling edge that follows the write's rising edge, which is the one cycle in which the request must appear. The contents of the table cannot be read directly. Counts, decay and replacement are therefore checked by the exact write number on which a request appears, and by checking that no request appears on the write just before it.

// File: rtl/wiq_pkg.sv
package wiq_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic touch;       // write hit touches the target entry
    logic insert;      // target gets a new address
    logic clearEntry;  // target is released after a swap request
    logic decay;       // age all other entries by one
  } wiq_cmd_t;
endpackage

// File: rtl/wiq_datapath.sv
module wiq_datapath
  import wiq_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wiq_cmd_t          cmd,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ENTRIES-1:0] freeVec,
  output logic [ENTRIES-1:0] lruVec,
  output logic [CNT_W-1:0]  hitCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] OLDEST  = IDX_W'(ENTRIES - 1);

  logic [ADDR_W-1:0] tagQ  [ENTRIES];
  logic [CNT_W-1:0]  cntQ  [ENTRIES];
  logic [IDX_W-1:0]  rankQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] selVec;
  logic [IDX_W-1:0]  tgtRank;

  for (genvar g = 0; g < ENTRIES; g++) begin : gLookup
    assign hitVec[g]  = validQ[g] && (tagQ[g] == wrAddr);
    assign freeVec[g] = !validQ[g];
    assign lruVec[g]  = (rankQ[g] == OLDEST);
    assign selVec[g]  = cmd.touch && (tgtIdx == IDX_W'(g));
  end

  always_comb begin
    hitCnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitCnt = hitCnt | cntQ[i];
    end
  end

  assign tgtRank = rankQ[tgtIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]  <= '0;
        cntQ[i]  <= '0;
        rankQ[i] <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (selVec[i]) begin
          if (cmd.clearEntry) begin
            validQ[i] <= 1'b0;
            cntQ[i]   <= '0;
          end else if (cmd.insert) begin
            validQ[i] <= 1'b1;
            tagQ[i]   <= wrAddr;
            cntQ[i]   <= CNT_W'(1);
          end else if (cntQ[i] != CNT_MAX) begin
            cntQ[i] <= cntQ[i] + 1'b1;
          end
        end else if (cmd.decay && validQ[i]) begin
          cntQ[i] <= cntQ[i] - 1'b1;
          if (cntQ[i] == CNT_W'(1)) validQ[i] <= 1'b0;
        end
        if (cmd.touch) begin
          if (selVec[i])                rankQ[i] <= '0;
          else if (rankQ[i] < tgtRank)  rankQ[i] <= rankQ[i] + 1'b1;
        end
      end
    end
  end

  // R3: an address is never tracked twice
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R4: ranks stay a permutation, so exactly one oldest entry
  a_r4_one_oldest: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lruVec) == 1);

  for (genvar g = 0; g < ENTRIES; g++) begin : gChk
    // R2: a plain hit below saturation adds exactly one
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
      (selVec[g] && !cmd.insert && !cmd.clearEntry && cntQ[g] != CNT_MAX)
      |=> cntQ[g] == $past(cntQ[g]) + 1'b1);
    // R5: a tracked entry always holds a non-zero count
    a_r5_valid_nonzero: assert property (@(posedge clk) disable iff (!rstN)
      validQ[g] |-> cntQ[g] != '0);
  end
endmodule

// File: rtl/wiq_ctrl.sv
module wiq_ctrl
  import wiq_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 26,
  parameter int CNT_W      = 4,
  parameter int SWAP_LEVEL = 11,
  parameter int DECAY_LOG2 = 11,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrHit,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic                  wrInLowRet,
  input  logic [DECAY_LOG2-1:0] cycleCnt,
  input  logic [ENTRIES-1:0]    hitVec,
  input  logic [ENTRIES-1:0]    freeVec,
  input  logic [ENTRIES-1:0]    lruVec,
  input  logic [CNT_W-1:0]      hitCnt,
  output wiq_cmd_t              cmd,
  output logic [IDX_W-1:0]      tgtIdx,
  output logic                  swapReq,
  output logic [ADDR_W-1:0]     swapAddr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LEVEL   = CNT_W'(SWAP_LEVEL);

  function automatic logic [IDX_W-1:0] lowestSet(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic anyHit, anyFree, crossing;
  logic [CNT_W-1:0] nextCnt;

  assign anyHit  = |hitVec;
  assign anyFree = |freeVec;
  assign nextCnt = (hitCnt == CNT_MAX) ? CNT_MAX : hitCnt + 1'b1;
  assign crossing = wrHit && anyHit && (nextCnt >= LEVEL);

  always_comb begin
    if (anyHit)       tgtIdx = lowestSet(hitVec);
    else if (anyFree) tgtIdx = lowestSet(freeVec);
    else              tgtIdx = lowestSet(lruVec);
    cmd.touch      = wrHit;
    cmd.insert     = wrHit && !anyHit;
    cmd.clearEntry = crossing && !wrInLowRet;
    cmd.decay      = (cycleCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swapReq  <= 1'b0;
      swapAddr <= '0;
    end else begin
      swapReq <= cmd.clearEntry;
      if (cmd.clearEntry) swapAddr <= wrAddr;
    end
  end

  // R8: a request always follows a write hit outside the low-retention region
  a_r8_req_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |-> $past(wrHit && !wrInLowRet));

  // R7: a write to a block already in the fast region never requests
  a_r7_lowret_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && wrInLowRet) |=> !swapReq);

  // R6: the request carries the written address
  a_r6_addr_match: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |-> swapAddr == $past(wrAddr));
endmodule

// File: rtl/wr_intensity_queue.sv
module wr_intensity_queue
  import wiq_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 26,
  parameter int CNT_W      = 4,
  parameter int SWAP_LEVEL = 11,
  parameter int DECAY_LOG2 = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrHit,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic                  wrInLowRet,
  input  logic [DECAY_LOG2-1:0] cycleCnt,
  output logic                  swapReq,
  output logic [ADDR_W-1:0]     swapAddr
);
  localparam int IDX_W = $clog2(ENTRIES);

  wiq_cmd_t cmd;
  logic [IDX_W-1:0]   tgtIdx;
  logic [ENTRIES-1:0] hitVec, freeVec, lruVec;
  logic [CNT_W-1:0]   hitCnt;

  wiq_ctrl #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .SWAP_LEVEL(SWAP_LEVEL), .DECAY_LOG2(DECAY_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrHit(wrHit), .wrAddr(wrAddr),
    .wrInLowRet(wrInLowRet), .cycleCnt(cycleCnt),
    .hitVec(hitVec), .freeVec(freeVec), .lruVec(lruVec), .hitCnt(hitCnt),
    .cmd(cmd), .tgtIdx(tgtIdx), .swapReq(swapReq), .swapAddr(swapAddr)
  );

  wiq_datapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tgtIdx(tgtIdx), .wrAddr(wrAddr),
    .hitVec(hitVec), .freeVec(freeVec), .lruVec(lruVec), .hitCnt(hitCnt)
  );
endmodule

// File: tb/wr_intensity_queue_bench.sv
module wr_intensity_queue_bench;
  localparam int AW = 26;
  localparam int DL = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrHit = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic wrInLowRet = 1'b0;
  logic [DL-1:0] cycleCnt = DL'(1);
  logic swapReq;
  logic [AW-1:0] swapAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  wr_intensity_queue u_wr_intensity_queue (
    .clk(clk), .rstN(rstN), .wrHit(wrHit), .wrAddr(wrAddr),
    .wrInLowRet(wrInLowRet), .cycleCnt(cycleCnt),
    .swapReq(swapReq), .swapAddr(swapAddr)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrHit = 1'b0; cycleCnt = DL'(1);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One write hit; request is sampled one cycle after the write edge
  task automatic doWrite(input logic [AW-1:0] a, input logic lr, input bit decayNow,
                         output logic gotReq, output logic [AW-1:0] gotAddr);
    @(negedge clk);
    wrHit = 1'b1; wrAddr = a; wrInLowRet = lr;
    cycleCnt = decayNow ? '0 : DL'(1);
    @(negedge clk);
    wrHit = 1'b0; cycleCnt = DL'(1);
    gotReq = swapReq; gotAddr = swapAddr;
  endtask

  // n writes; only the last may request, and must equal expLast
  task automatic writeN(input logic [AW-1:0] a, input logic lr, input int n,
                        input bit expLast, input string req);
    logic r;
    logic [AW-1:0] ra;
    for (int k = 1; k <= n; k++) begin
      doWrite(a, lr, 1'b0, r, ra);
      if (k < n) check(r == 1'b0, req, "early request", r, 0);
      else begin
        check(r == expLast, req, "request on final write", r, expLast);
        if (expLast) check(ra == a, req, "swap address", ra, a);
      end
    end
  endtask

  task automatic decayPulse();
    @(negedge clk); cycleCnt = '0;
    @(negedge clk); cycleCnt = DL'(1);
  endtask

  task automatic tReset();
    doReset();
    check(swapReq == 1'b0, "R1", "swapReq after reset", swapReq, 0);
    // R1/R3: fresh address starts at 1, request on 11th write
    writeN(AW'(26'h11), 1'b0, 11, 1'b1, "R3");
  endtask

  task automatic tBasic();
    doReset();
    writeN(AW'(26'h2A0), 1'b0, 11, 1'b1, "R6");
    @(negedge clk);
    check(swapReq == 1'b0, "R8", "request held past one cycle", swapReq, 0);
    // R6: entry freed, so the address starts over
    writeN(AW'(26'h2A0), 1'b0, 11, 1'b1, "R6");
  endtask

  task automatic tLowRet();
    doReset();
    writeN(AW'(26'h3B1), 1'b1, 20, 1'b0, "R7");
    // R2: count saturated but still at or past the level
    writeN(AW'(26'h3B1), 1'b0, 1, 1'b1, "R2");
  endtask

  task automatic tDecay();
    logic r;
    logic [AW-1:0] ra;
    doReset();
    writeN(AW'(26'h40), 1'b0, 5, 1'b0, "R5");   // C = 5
    writeN(AW'(26'h41), 1'b0, 5, 1'b0, "R5");   // E = 5
    decayPulse();
    decayPulse();                               // C = 3, E = 3
    doWrite(AW'(26'h40), 1'b0, 1'b1, r, ra);    // C = 4 (exempt), E = 2
    check(r == 1'b0, "R5", "request during decay write", r, 0);
    writeN(AW'(26'h40), 1'b0, 7, 1'b1, "R5");   // C reaches 11
    writeN(AW'(26'h41), 1'b0, 9, 1'b1, "R5");   // E reaches 11
  endtask

  task automatic tLru();
    doReset();
    for (int j = 0; j < 16; j++) writeN(AW'(26'h100 + j), 1'b0, 5, 1'b0, "R4");
    writeN(AW'(26'h100), 1'b0, 1, 1'b0, "R4");   // oldest now 0x101
    writeN(AW'(26'h200), 1'b0, 1, 1'b0, "R4");   // evicts 0x101
    // evicted address restarts at 1: no request after 6 writes
    writeN(AW'(26'h101), 1'b0, 6, 1'b0, "R4");
    // 0x100 survived with count 6: request on 5th more write
    writeN(AW'(26'h100), 1'b0, 5, 1'b1, "R4");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tReset();
    tBasic();
    tLowRet();
    tDecay();
    tLru();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule